// File: doc/BRIEF.md
# Stepper Phase Current Chopper Controller

This block runs one H-bridge phase of a bipolar stepper motor. A two-bit level code chooses the phase current. A direction bit chooses the polarity. A digital trip input comes from an external current-sense comparator, and it tells the block that the phase current has reached the selected threshold. The block produces two kinds of output. The first is a two-bit threshold select for that comparator. The second is four gate enables, a high and a low gate for each of the two bridge legs, called leg A and leg B.

The level code is `level_i`, where bit 0 is the low-weight bit. Code 00 selects the 100 % threshold, 01 selects 66 %, 10 selects 33 %, and 11 selects 0 %. Code 11 also means fast decay: every gate is removed, and the winding current flows back to the supply. For any other code the block chops at constant off time. It drives the bridge and ignores the comparator for a blanking window. It then watches the comparator. When the comparator trips, it turns every gate off for a fixed off time and then drives again. Before the bridge turns on from the fully off state, and whenever the direction reverses while the bridge is driving, all gates are held off for a dead time. Standby, thermal fault and reset each force every gate off.

The controller is a five-state machine:

- IDLE: every gate is off. The block is forced off, or the level code is 11, or it has just left reset.
- DEAD: every gate is off for `DEAD_CYC` cycles.
- BLANK: the bridge drives for `BLANK_CYC` cycles and the trip input is ignored.
- DRIVE: the bridge drives and the trip input is watched.
- OFF: every gate is off for `OFF_CYC` cycles.

The transitions are as follows:

- IDLE goes to DEAD.
- DEAD goes to BLANK when its time runs out, and the direction is latched at that point.
- BLANK goes to DRIVE when its time runs out.
- DRIVE goes to OFF on a trip.
- OFF goes to BLANK when its time runs out, and the direction is latched again.
- BLANK or DRIVE goes to DEAD when `dir_i` differs from the latched direction.
- Any state goes to IDLE when the block is forced off or the level code is 11.

Top module: `stepper_phase_chopper`

## Requirements
- R1: While `rst_n` is low, which is an asynchronous reset, all four gates are 0 and `thr_sel_o` is 11.
- R2: When the block is not forced off, `thr_sel_o` equals the `level_i` code of the previous cycle: 00 selects 100 %, 01 selects 66 %, 10 selects 33 % and 11 selects 0 %.
- R3: While driving, `dir_i`=1 enables `gate_ah_o` and `gate_bl_o`, and `dir_i`=0 enables `gate_bh_o` and `gate_al_o`. In the bit order {ah,al,bh,bl} these are 1001 and 0110.
- R4: Leaving IDLE, the gates stay off for `DEAD_CYC` cycles before driving begins.
- R5: The trip input is ignored during the first `BLANK_CYC` cycles of every drive period.
- R6: A trip seen after blanking turns all gates off for exactly `OFF_CYC` cycles, after which driving resumes.
- R7: A direction change seen while driving turns all gates off for `DEAD_CYC` cycles, after which the bridge drives with the new polarity. The gates never reverse directly.
- R8: A direction change made during the off time takes effect when driving resumes, with no extra dead time.
- R9: Level code 11 turns all gates off on the next cycle. This is fast decay.
- R10: When `standby_i` or `therm_fault_i` is high, all gates go off and `thr_sel_o` becomes 11 on the next cycle. Trip and direction inputs have no effect while the block is forced off.
- R11: The high and low gates of the same leg are never on in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| level_i | input | 2 | Current level code (11 = fast decay) |
| dir_i | input | 1 | Current direction; 1 sources from leg A |
| trip_i | input | 1 | Current-sense comparator trip |
| standby_i | input | 1 | Standby; forces the bridge off |
| therm_fault_i | input | 1 | Thermal fault; forces the bridge off |
| thr_sel_o | output | 2 | Comparator threshold select |
| gate_ah_o | output | 1 | Leg A high-side gate enable |
| gate_al_o | output | 1 | Leg A low-side gate enable |
| gate_bh_o | output | 1 | Leg B high-side gate enable |
| gate_bl_o | output | 1 | Leg B low-side gate enable |

## Verification
The assertions take for granted that every control input is synchronous to `clk`. In particular, the trip input is expected to be already synchronised rather than coming straight from the comparator. They also assume that a trip only matters when it is seen on a clock edge. The stimulus meets these assumptions by changing every input on the falling clock edge, so that each rising edge sees stable values. It uses single-cycle trip pulses, placed so that one lands inside the blanking window and another lands after it. It also places direction changes in the DRIVE state, in the OFF state and during a thermal fault.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DEAD  = 3'd1,
        ST_BLANK = 3'd2,
        ST_DRIVE = 3'd3,
        ST_OFF   = 3'd4
    } chop_state_e;

    // Level code that means zero current and fast decay
    localparam logic [1:0] LVL_ZERO = 2'b11;

    typedef struct packed {
        logic a_hi;
        logic a_lo;
        logic b_hi;
        logic b_lo;
    } bridge_gates_t;

endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
    import chop_pkg::*;
#(
    parameter int OFF_CYC   = 7500,
    parameter int BLANK_CYC = 250,
    parameter int DEAD_CYC  = 125
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hold_off,
    input  logic [1:0]  level,
    input  logic        dir,
    input  logic        trip,
    output chop_state_e state,
    output logic        drive_dir
);

    localparam int MAX_AB  = (OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC;
    localparam int MAX_CYC = (MAX_AB > DEAD_CYC) ? MAX_AB : DEAD_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] OFF_LD   = CNT_W'(OFF_CYC - 1);
    localparam logic [CNT_W-1:0] BLANK_LD = CNT_W'(BLANK_CYC - 1);
    localparam logic [CNT_W-1:0] DEAD_LD  = CNT_W'(DEAD_CYC - 1);

    chop_state_e      state_q, state_d;
    logic             dir_q;
    logic             dir_take;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             stop_all;

    assign stop_all = hold_off || (level == LVL_ZERO);

    chop_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (dir_take) begin
                dir_q <= dir;
            end
        end
    end

    // Next state and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        dir_take = 1'b0;
        if (stop_all) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d  = ST_DEAD;
                    tmr_load = 1'b1;
                    tmr_val  = DEAD_LD;
                end
                ST_DEAD: begin
                    if (tmr_done) begin
                        state_d  = ST_BLANK;
                        tmr_load = 1'b1;
                        tmr_val  = BLANK_LD;
                        dir_take = 1'b1;
                    end
                end
                ST_BLANK: begin
                    if (dir != dir_q) begin
                        state_d  = ST_DEAD;
                        tmr_load = 1'b1;
                        tmr_val  = DEAD_LD;
                    end else if (tmr_done) begin
                        state_d = ST_DRIVE;
                    end
                end
                ST_DRIVE: begin
                    if (dir != dir_q) begin
                        state_d  = ST_DEAD;
                        tmr_load = 1'b1;
                        tmr_val  = DEAD_LD;
                    end else if (trip) begin
                        state_d  = ST_OFF;
                        tmr_load = 1'b1;
                        tmr_val  = OFF_LD;
                    end
                end
                ST_OFF: begin
                    if (tmr_done) begin
                        state_d  = ST_BLANK;
                        tmr_load = 1'b1;
                        tmr_val  = BLANK_LD;
                        dir_take = 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        state     = state_q;
        drive_dir = dir_q;
    end

    // R7
    dir_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_all && (state_q == ST_BLANK || state_q == ST_DRIVE) && dir != dir_q)
        |=> state_q == ST_DEAD);

    // R6
    trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_all && state_q == ST_DRIVE && dir == dir_q && trip)
        |=> state_q == ST_OFF);

    // R5
    blank_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLANK && !tmr_done) |=> state_q != ST_OFF);

    // R4
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (state_q == ST_IDLE || state_q == ST_DEAD));

endmodule

// File: rtl/chop_gate_map.sv
module chop_gate_map
    import chop_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  chop_state_e   state,
    input  logic          drive_dir,
    output bridge_gates_t gates
);

    logic on;

    always_comb begin
        on         = (state == ST_BLANK) || (state == ST_DRIVE);
        gates.a_hi = on &&  drive_dir;
        gates.b_lo = on &&  drive_dir;
        gates.b_hi = on && !drive_dir;
        gates.a_lo = on && !drive_dir;
    end

    // R11
    leg_a_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gates.a_hi && gates.a_lo));

    // R11
    leg_b_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gates.b_hi && gates.b_lo));

    // R3
    diagonal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gates != '0) |-> ($countones(gates) == 2 &&
                           gates.a_hi == gates.b_lo && gates.b_hi == gates.a_lo));

    // R7
    no_direct_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gates != '0 && $past(gates) != '0) |-> gates == $past(gates));

endmodule

// File: rtl/stepper_phase_chopper.sv
module stepper_phase_chopper
    import chop_pkg::*;
#(
    parameter int OFF_CYC   = 7500,
    parameter int BLANK_CYC = 250,
    parameter int DEAD_CYC  = 125
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] level_i,
    input  logic       dir_i,
    input  logic       trip_i,
    input  logic       standby_i,
    input  logic       therm_fault_i,
    output logic [1:0] thr_sel_o,
    output logic       gate_ah_o,
    output logic       gate_al_o,
    output logic       gate_bh_o,
    output logic       gate_bl_o
);

    chop_state_e   state;
    logic          drive_dir;
    bridge_gates_t gates;
    logic          forced;
    logic [1:0]    sel_q;

    assign forced = standby_i || therm_fault_i;

    chop_fsm #(
        .OFF_CYC   (OFF_CYC),
        .BLANK_CYC (BLANK_CYC),
        .DEAD_CYC  (DEAD_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_off  (forced),
        .level     (level_i),
        .dir       (dir_i),
        .trip      (trip_i),
        .state     (state),
        .drive_dir (drive_dir)
    );

    chop_gate_map u_gates (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .drive_dir (drive_dir),
        .gates     (gates)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= LVL_ZERO;
        end else begin
            sel_q <= forced ? LVL_ZERO : level_i;
        end
    end

    assign thr_sel_o = sel_q;
    assign gate_ah_o = gates.a_hi;
    assign gate_al_o = gates.a_lo;
    assign gate_bh_o = gates.b_hi;
    assign gate_bl_o = gates.b_lo;

    // R10
    forced_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        forced |=> (gates == '0 && thr_sel_o == LVL_ZERO));

    // R9
    zero_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i == LVL_ZERO) |=> gates == '0);

    // R2
    sel_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !forced |=> thr_sel_o == $past(level_i));

endmodule

// File: tb/stepper_phase_chopper_test.sv
`timescale 1ns/1ps
module stepper_phase_chopper_test;

    localparam int B = 10;

    typedef struct {
        int         at;
        logic [3:0] g;
        logic [1:0] s;
        string      tag;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] level_i = 2'b00;
    logic       dir_i = 1'b1;
    logic       trip_i = 1'b0;
    logic       standby_i = 1'b0;
    logic       therm_fault_i = 1'b0;
    logic [1:0] thr_sel_o;
    logic       gate_ah_o, gate_al_o, gate_bh_o, gate_bl_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_item_t exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    stepper_phase_chopper #(
        .OFF_CYC   (40),
        .BLANK_CYC (8),
        .DEAD_CYC  (5)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .level_i       (level_i),
        .dir_i         (dir_i),
        .trip_i        (trip_i),
        .standby_i     (standby_i),
        .therm_fault_i (therm_fault_i),
        .thr_sel_o     (thr_sel_o),
        .gate_ah_o     (gate_ah_o),
        .gate_al_o     (gate_al_o),
        .gate_bh_o     (gate_bh_o),
        .gate_bl_o     (gate_bl_o)
    );

    task automatic push(input int at, input logic [3:0] g, input logic [1:0] s,
                        input string tag);
        exp_item_t it;
        it.at = at; it.g = g; it.s = s; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic go(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Monitor: samples after each falling edge
    initial begin
        forever begin
            logic [3:0] g;
            exp_item_t  it;
            @(negedge clk);
            #1;
            g = {gate_ah_o, gate_al_o, gate_bh_o, gate_bl_o};
            checks++;
            if ((g[3] && g[2]) || (g[1] && g[0])) begin
                errors++;
                $display("FAIL R11 cycle %0d: gates %b, expected no leg with both gates on", cyc, g);
            end
            while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
                it = exp_q.pop_front();
                checks++;
                if (it.at != cyc || g !== it.g || thr_sel_o !== it.s) begin
                    errors++;
                    $display("FAIL %s cycle %0d: gates %b sel %b, expected gates %b sel %b",
                             it.tag, cyc, g, thr_sel_o, it.g, it.s);
                end
            end
        end
    end

    // Driver
    initial begin
        push(3, 4'b0000, 2'b11, "R1 reset state");
        go(B);
        rst_n = 1'b1;
        push(B+1, 4'b0000, 2'b00, "R4 dead after start");
        push(B+5, 4'b0000, 2'b00, "R4 dead last cycle");
        push(B+6, 4'b1001, 2'b00, "R3 dir=1 drive");
        go(B+8);  trip_i = 1'b1;
        go(B+9);  trip_i = 1'b0;
        push(B+9,  4'b1001, 2'b00, "R5 trip in blank ignored");
        push(B+14, 4'b1001, 2'b00, "R5 still driving");
        go(B+20); trip_i = 1'b1;
        push(B+20, 4'b1001, 2'b00, "R6 before trip");
        go(B+21); trip_i = 1'b0;
        push(B+21, 4'b0000, 2'b00, "R6 off begins");
        push(B+60, 4'b0000, 2'b00, "R6 off last cycle");
        push(B+61, 4'b1001, 2'b00, "R6 drive resumes");
        go(B+75); dir_i = 1'b0;
        push(B+75, 4'b1001, 2'b00, "R7 before reversal");
        push(B+76, 4'b0000, 2'b00, "R7 dead begins");
        push(B+80, 4'b0000, 2'b00, "R7 dead last cycle");
        push(B+81, 4'b0110, 2'b00, "R7 R3 dir=0 drive");
        go(B+90); level_i = 2'b01;
        push(B+91, 4'b0110, 2'b01, "R2 66 percent");
        go(B+95); level_i = 2'b10;
        push(B+96, 4'b0110, 2'b10, "R2 33 percent");
        go(B+100); level_i = 2'b11;
        push(B+100, 4'b0110, 2'b10, "R9 before zero level");
        push(B+101, 4'b0000, 2'b11, "R9 fast decay");
        go(B+110); level_i = 2'b00;
        push(B+111, 4'b0000, 2'b00, "R4 dead after zero level");
        push(B+115, 4'b0000, 2'b00, "R4 dead last cycle");
        push(B+116, 4'b0110, 2'b00, "R4 drive after dead");
        go(B+130); standby_i = 1'b1;
        push(B+131, 4'b0000, 2'b11, "R10 standby off");
        go(B+132); trip_i = 1'b1;
        go(B+133); trip_i = 1'b0;
        push(B+135, 4'b0000, 2'b11, "R10 trip ignored in standby");
        go(B+140); standby_i = 1'b0;
        push(B+141, 4'b0000, 2'b00, "R10 R4 leave standby");
        push(B+146, 4'b0110, 2'b00, "R10 drive after standby");
        go(B+160); therm_fault_i = 1'b1;
        push(B+161, 4'b0000, 2'b11, "R10 thermal off");
        go(B+165); dir_i = 1'b1;
        push(B+168, 4'b0000, 2'b11, "R10 dir ignored in fault");
        go(B+170); therm_fault_i = 1'b0;
        push(B+175, 4'b0000, 2'b00, "R4 dead after fault");
        push(B+176, 4'b1001, 2'b00, "R3 dir=1 after fault");
        go(B+190); trip_i = 1'b1;
        go(B+191); trip_i = 1'b0;
        push(B+191, 4'b0000, 2'b00, "R6 off after trip");
        go(B+200); dir_i = 1'b0;
        push(B+230, 4'b0000, 2'b00, "R8 off time unchanged");
        push(B+231, 4'b0110, 2'b00, "R8 new dir without dead");
        go(B+240); rst_n = 1'b0;
        push(B+240, 4'b0000, 2'b11, "R1 async reset");
        go(B+245); rst_n = 1'b1;
        push(B+245, 4'b0000, 2'b11, "R1 reset just released");
        push(B+246, 4'b0000, 2'b00, "R4 dead after reset");
        push(B+251, 4'b0110, 2'b00, "R4 drive after reset");
        go(B+260);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, cycle %0d, expected end by %0d", cyc, B+260);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule